// File: doc/BRIEF.md
# Bus Interrupt Status Register

This block keeps the interrupt cause for a bus bridge controller. Ten general event strobes come from the bus protocol engine, and one more cause comes from a built-in detector. The detector watches I/O target transfers. It flags a target-abort when a byte lane below the address offset is enabled. The register keeps only one cause at a time. When the register is empty, the first event to arrive is latched and later events are ignored. If several events arrive in the same cycle, the lowest-numbered one wins.

The local CPU reads the register and clears causes by writing 1 to them. The bus side sees the same word through a read-only port. Each cause has an enable bit. A cause is recorded even while its enable is off, but only enabled causes drive the interrupt request. The request is registered.

Top module: `bus_irq_status`

## Requirements
- R1: After reset every status bit reads 0 on both read ports, and `irq` is 0.
- R2: With the register empty, a one-cycle pulse on `evt_stb[i]` (i in 0..9) sets status bit i. The bit is visible on the read ports after that clock edge, and the rest of the word stays 0.
- R3: If several causes arrive in one cycle with the register empty, only the lowest-numbered one is latched. The order is bit 0 first up to bit 9, and the target-abort (bit 14) comes last.
- R4: While any status bit is set and not being cleared, new events are dropped and the word does not change.
- R5: An event whose enable is 0 still sets its status bit, but `irq` stays 0 for it.
- R6: `irq` is 1 in the cycle after an enabled status bit is 1. It returns to 0 in the cycle after no enabled status bit is set.
- R7: Bit 14 is set when `io_tgt_valid` is 1 and some active-low lane of `io_be_n` is enabled (0) at a lane index below `io_addr_lo`. If no lane below the offset is enabled, including the case where all lanes are off, nothing is set. Nothing is set while `io_tgt_valid` is 0.
- R8: A CPU write (`cpu_wr`=1) clears every status bit whose `cpu_wdata` bit is 1. Bits written 0 keep their value.
- R9: If a clear empties the register in the same cycle as a new event, the new event is latched. If the clear leaves a bit set, the event is dropped.
- R10: Bits 31..15 and 13..10 always read 0, and writes to them have no effect.
- R11: `bus_rdata` always equals `cpu_rdata`, and no bus-side input can change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_stb | input | 10 | Event strobes for status bits 9..0 |
| io_tgt_valid | input | 1 | An I/O target transfer is presenting address and byte enables |
| io_addr_lo | input | 2 | Low two address bits of that transfer |
| io_be_n | input | 4 | Byte enables of that transfer, active low |
| src_en | input | 10 | Interrupt enables for bits 9..0 |
| tabort_en | input | 1 | Interrupt enable for the target-abort bit |
| cpu_wr | input | 1 | CPU write strobe, write-1-to-clear |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU view of the status word |
| bus_rdata | output | 32 | Bus-side read-only view of the status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear and a new event landing on the same edge. There are two ways this can go: the clear empties the register, so the event must be taken, or the clear misses the pending bit, so the event must be dropped. The bench first loads a known single cause. It then drives `cpu_wr` and one strobe in the same cycle, once with a matching clear mask and once with a non-matching one. It checks the word after that edge. The target-abort detector is driven with offsets and lane patterns on both sides of the rule, including all lanes off and a lane exactly at the offset.

// File: rtl/bus_irq_status.sv
module bus_irq_status #(
  parameter int NGEN   = 10,
  parameter int TA_POS = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGEN-1:0] evt_stb,
  input  logic            io_tgt_valid,
  input  logic [1:0]      io_addr_lo,
  input  logic [3:0]      io_be_n,
  input  logic [NGEN-1:0] src_en,
  input  logic            tabort_en,
  input  logic            cpu_wr,
  input  logic [31:0]     cpu_wdata,
  output logic [31:0]     cpu_rdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);

  localparam int NS = NGEN + 1;

  logic [NS-1:0] st_q, st_d, kept, clr, evt, pick, en_all;
  logic [3:0]    below_mask;
  logic          ta_evt;
  logic          unused_wdata;

  assign below_mask = (4'd1 << io_addr_lo) - 4'd1;
  assign ta_evt     = io_tgt_valid && |(~io_be_n & below_mask);

  assign evt    = {ta_evt, evt_stb};
  assign pick   = evt & (~evt + NS'(1));
  assign clr    = cpu_wr ? {cpu_wdata[TA_POS], cpu_wdata[NGEN-1:0]} : '0;
  assign kept   = st_q & ~clr;
  assign st_d   = (kept == '0) ? pick : kept;
  assign en_all = {tabort_en, src_en};

  assign unused_wdata = ^{cpu_wdata[31:TA_POS+1], cpu_wdata[TA_POS-1:NGEN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_d;
      irq  <= |(st_q & en_all);
    end
  end

  always_comb begin
    cpu_rdata = '0;
    cpu_rdata[NGEN-1:0] = st_q[NGEN-1:0];
    cpu_rdata[TA_POS]   = st_q[NS-1];
  end

  assign bus_rdata = cpu_rdata;

  // R3
  single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_rdata));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[31:TA_POS+1] == '0 && cpu_rdata[TA_POS-1:NGEN] == '0);

  // R4
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata != '0 && !cpu_wr) |=> $stable(cpu_rdata));

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata == '0 && evt_stb != '0) |=> cpu_rdata != '0);

  // R6
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata == '0) |=> !irq);

  // R11
  bus_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == cpu_rdata);

endmodule

// File: tb/bus_irq_status_test.sv
module bus_irq_status_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  evt_stb = '0;
  logic        io_tgt_valid = 0;
  logic [1:0]  io_addr_lo = '0;
  logic [3:0]  io_be_n = 4'hF;
  logic [9:0]  src_en = '0;
  logic        tabort_en = 0;
  logic        cpu_wr = 0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata, bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  bus_irq_status uut (.*);

  always #10 clk = ~clk;

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_all();
    cpu_wr = 1; cpu_wdata = 32'hFFFF_FFFF; step(); cpu_wr = 0; cpu_wdata = '0; step();
  endtask

  task automatic pulse(input logic [9:0] s);
    evt_stb = s; step(); evt_stb = '0;
  endtask

  task automatic t_reset();
    check("R1 cpu", cpu_rdata, 0);
    check("R1 bus", bus_rdata, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 10; i++) begin
      pulse(10'd1 << i);
      check("R2 single", cpu_rdata, 32'd1 << i);
      check("R11 bus", bus_rdata, 32'd1 << i);
      clear_all();
    end
  endtask

  task automatic t_priority();
    pulse(10'b1010000000);
    check("R3 two strobes", cpu_rdata, 32'h80);
    clear_all();
    io_tgt_valid = 1; io_addr_lo = 2'd1; io_be_n = 4'b1110; evt_stb = 10'h200;
    step(); io_tgt_valid = 0; io_be_n = 4'hF; evt_stb = '0;
    check("R3 bit9 beats abort", cpu_rdata, 32'h200);
    clear_all();
    pulse(10'h3FF);
    check("R3 all strobes", cpu_rdata, 32'h1);
    clear_all();
  endtask

  task automatic t_block();
    pulse(10'h010);
    pulse(10'h001);
    check("R4 later dropped", cpu_rdata, 32'h10);
    pulse(10'h3FF);
    check("R4 still first", cpu_rdata, 32'h10);
    clear_all();
  endtask

  task automatic t_enable();
    src_en = '0;
    pulse(10'h004);
    check("R5 disabled recorded", cpu_rdata, 32'h4);
    step();
    check("R5 no irq", irq, 0);
    clear_all();
    src_en = 10'h004;
    evt_stb = 10'h004; @(posedge clk); #1;
    check("R6 no irq same edge", irq, 0);
    evt_stb = '0;
    step();
    check("R6 irq next cycle", irq, 1);
    cpu_wr = 1; cpu_wdata = 32'h4; step(); cpu_wr = 0; cpu_wdata = '0;
    check("R6 irq held one cycle", irq, 1);
    step();
    check("R6 irq drops", irq, 0);
    src_en = '0;
  endtask

  task automatic abort_case(input logic [1:0] a, input logic [3:0] be, input logic v,
                            input logic [31:0] exp, input string tag);
    io_tgt_valid = v; io_addr_lo = a; io_be_n = be;
    step();
    io_tgt_valid = 0; io_be_n = 4'hF; io_addr_lo = '0;
    check(tag, cpu_rdata, exp);
    clear_all();
  endtask

  task automatic t_abort();
    abort_case(2'd1, 4'b1110, 1, 32'h4000, "R7 lane0 below off1");
    abort_case(2'd3, 4'b1101, 1, 32'h4000, "R7 lane1 below off3");
    abort_case(2'd2, 4'b0011, 1, 32'h0,    "R7 lanes at offset ok");
    abort_case(2'd3, 4'b0111, 1, 32'h0,    "R7 lane3 off3 ok");
    abort_case(2'd3, 4'b1111, 1, 32'h0,    "R7 all lanes off ok");
    abort_case(2'd0, 4'b0000, 1, 32'h0,    "R7 off0 all lanes ok");
    abort_case(2'd1, 4'b1110, 0, 32'h0,    "R7 not valid");
    tabort_en = 1;
    io_tgt_valid = 1; io_addr_lo = 2'd2; io_be_n = 4'b1101; step();
    io_tgt_valid = 0; io_be_n = 4'hF; step();
    check("R7 abort irq", irq, 1);
    tabort_en = 0;
    clear_all();
  endtask

  task automatic t_clear();
    pulse(10'h020);
    cpu_wr = 1; cpu_wdata = '0; step(); cpu_wr = 0;
    check("R8 write zero keeps", cpu_rdata, 32'h20);
    cpu_wr = 1; cpu_wdata = 32'hFFFF_BC1F; step(); cpu_wr = 0; cpu_wdata = '0;
    check("R8 other ones keep", cpu_rdata, 32'h20);
    cpu_wr = 1; cpu_wdata = 32'h20; step(); cpu_wr = 0; cpu_wdata = '0;
    check("R8 write one clears", cpu_rdata, 32'h0);
  endtask

  task automatic t_collide();
    pulse(10'h008);
    cpu_wr = 1; cpu_wdata = 32'h8; evt_stb = 10'h020; step();
    cpu_wr = 0; cpu_wdata = '0; evt_stb = '0;
    check("R9 event wins clear", cpu_rdata, 32'h20);
    cpu_wr = 1; cpu_wdata = 32'h1; evt_stb = 10'h002; step();
    cpu_wr = 0; cpu_wdata = '0; evt_stb = '0;
    check("R9 missed clear drops event", cpu_rdata, 32'h20);
    clear_all();
  endtask

  task automatic t_reserved();
    cpu_wr = 1; cpu_wdata = 32'hFFFF_BC00; evt_stb = '0; step(); cpu_wr = 0; cpu_wdata = '0;
    check("R10 reserved read zero", cpu_rdata, 32'h0);
    pulse(10'h200);
    check("R10 only bit9", cpu_rdata & 32'hFFFF_BC00, 32'h0);
    check("R11 bus matches", bus_rdata, cpu_rdata);
    clear_all();
  endtask

  initial begin
    #45; @(negedge clk);
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_single();
    t_priority();
    t_block();
    t_enable();
    t_abort();
    t_clear();
    t_collide();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule